// File: doc/BRIEF.md
# Cluster Performance-Level Request Controller

This block sits behind a simple 32-bit register bus and accepts three kinds of request: a new performance-level index for CPU cluster 0, a new performance-level index for CPU cluster 1, and a command word that reads a value from a small internal configuration store. Only one request runs at a time. An accepted request keeps the block busy for a programmable number of clock cycles, which stands in for the few milliseconds a real voltage and frequency change takes. When that time is up, the block records the result as a complete flag or an error flag in a status register shared by all request types.

A level-high interrupt stays asserted while any status flag is set. Software reads the status register to learn the outcome. That read clears the flags and drops the interrupt. A second view of the same flags can be read without clearing them. A successful configuration read leaves its result in a read-data register. The busy delay is a parameter: the default is a few milliseconds at 200 MHz, and a testbench can shrink it to a handful of cycles.

Top module: `dvfs_ctrl`

## Requirements
- R1: After reset every readable register reads zero and `irq` is low.
- R2: A write to offset 0x00 (cluster 0) or offset 0x08 (cluster 1) starts a level change whose argument is the full write data. A write to 0x10 with bit 31 set starts a command. The request register for that type (0x04, 0x0C or 0x14) reads 1 while the operation runs. The result flag is set, and `irq` rises, exactly BUSY_CYCLES clock edges after the write edge.
- R3: The status flags are packed in 4-bit groups per request type t (0 = cluster 0, 1 = cluster 1, 2 = command): the complete flag is at bit 4*t and the error flag at bit 4*t+1. Each finished operation sets exactly one of the two.
- R4: A level index equal to or above that cluster's count of valid levels (NUM_LVL0 = 8, NUM_LVL1 = 5 by default) finishes with the error flag, and the cluster's level register keeps its old value.
- R5: Reading a cluster's level register returns the last index that finished with the complete flag.
- R6: A command word carries its function code in bits 27:20 and a word offset in bits 19:0. Function 6 reads configuration word i, where word i is {16'hC5A0 ^ i, i*7+1} with each half 16 bits wide. An offset of CFG_WORDS (64) or more is an error. Function 14 returns {NUM_LVL1, NUM_LVL0} as two 16-bit halves. Any other function code is an error.
- R7: A write to 0x10 with bit 31 clear starts nothing and sets no flag.
- R8: Offset 0x74 returns the result of the last command that completed without error. An erroring command leaves it unchanged.
- R9: `irq` is high exactly while any status flag is set. A read of 0x18 returns the flags and clears them. A read of 0x1C returns the same flags and leaves them in place.
- R10: Any level or command write that arrives while an operation is busy is ignored. The running operation finishes with its own result, and no other register changes.
- R11: When a flag is being set on the same clock edge as a read of 0x18, the read returns the old flags and the new flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is valid on the following cycle |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level-high interrupt while any status flag is set |

## Verification
The bench checks the exact edge on which the flag appears. A design with an off-by-one in its busy counter would raise `irq` one cycle early or one cycle late. It sends level indices just inside and just outside each cluster's valid range, and command offsets at the last configuration word and one past it. A wrong comparison there would post the complete flag where the error flag belongs, or would overwrite the level or read-data register. It overlaps requests with a busy operation, which catches a design that restarts or retargets the running operation. It also lines up a status read with the edge on which a flag is set. A design that lets the clear win on that edge would lose the flag, and the interrupt for it would never be seen.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  typedef enum logic [1:0] {
    REQ_CL0 = 2'd0,
    REQ_CL1 = 2'd1,
    REQ_CMD = 2'd2
  } req_kind_t;

  localparam int NUM_REQ   = 3;
  localparam int GRP_W     = 4;
  localparam int STAT_W    = NUM_REQ * GRP_W;

  localparam logic [7:0] FN_CFGMEM = 8'd6;
  localparam logic [7:0] FN_LEVELS = 8'd14;

  localparam int CMD_GO_BIT = 31;
  localparam int FN_LSB     = 20;
  localparam int FN_MSB     = 27;

  localparam logic [7:0] OFF_LVL0   = 8'h00;
  localparam logic [7:0] OFF_BSY0   = 8'h04;
  localparam logic [7:0] OFF_LVL1   = 8'h08;
  localparam logic [7:0] OFF_BSY1   = 8'h0C;
  localparam logic [7:0] OFF_CMD    = 8'h10;
  localparam logic [7:0] OFF_BSYC   = 8'h14;
  localparam logic [7:0] OFF_STAT   = 8'h18;
  localparam logic [7:0] OFF_PEEK   = 8'h1C;
  localparam logic [7:0] OFF_RDDATA = 8'h74;

endpackage

// File: rtl/dvfs_cfg_mem.sv
module dvfs_cfg_mem #(
  parameter int WORDS = 64,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);

  logic [31:0] words [WORDS];

  // Contents are a fixed function of the word index.
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam logic [15:0] HI = 16'hC5A0 ^ 16'(i);
    localparam logic [15:0] LO = 16'(i * 7 + 1);
    assign words[i] = {HI, LO};
  end

  always_comb begin
    if (32'(rd_addr) < WORDS) rd_data = words[rd_addr];
    else                      rd_data = '0;
  end

endmodule

// File: rtl/dvfs_op_engine.sv
module dvfs_op_engine
  import dvfs_pkg::*;
#(
  parameter int BUSY_CYCLES = 800000,
  parameter int NUM_LVL0    = 8,
  parameter int NUM_LVL1    = 5,
  parameter int CFG_WORDS   = 64,
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1),
  localparam int CFG_AW     = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  req_kind_t         start_kind,
  input  logic [31:0]       start_arg,
  output logic              busy,
  output req_kind_t         cur_kind,
  output logic              done,
  output logic              done_err,
  output logic [31:0]       done_data,
  output logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_data
);

  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  req_kind_t         kind_q, kind_d;
  logic [31:0]       arg_q, arg_d;
  logic              accept;

  assign accept = start && !busy_q;
  assign done   = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    arg_d  = arg_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
      kind_d = start_kind;
      arg_d  = start_arg;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= REQ_CL0;
      arg_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      arg_q  <= arg_d;
    end
  end

  // Outcome of the running operation, decided from its latched argument.
  logic [7:0]  fn;
  logic [19:0] woff;
  assign fn       = arg_q[FN_MSB:FN_LSB];
  assign woff     = arg_q[19:0];
  assign cfg_addr = arg_q[CFG_AW-1:0];

  always_comb begin
    done_err  = 1'b0;
    done_data = '0;
    unique case (kind_q)
      REQ_CL0: done_err = (arg_q >= 32'(NUM_LVL0));
      REQ_CL1: done_err = (arg_q >= 32'(NUM_LVL1));
      default: begin
        if (fn == FN_CFGMEM) begin
          done_err  = (32'(woff) >= 32'(CFG_WORDS));
          done_data = cfg_data;
        end else if (fn == FN_LEVELS) begin
          done_data = {16'(NUM_LVL1), 16'(NUM_LVL0)};
        end else begin
          done_err  = 1'b1;
        end
      end
    endcase
  end

  assign busy     = busy_q;
  assign cur_kind = kind_q;

endmodule

// File: rtl/dvfs_status_reg.sv
module dvfs_status_reg
  import dvfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  req_kind_t         set_kind,
  input  logic              set_err,
  input  logic              clr,
  output logic [STAT_W-1:0] flags
);

  logic [STAT_W-1:0] flags_q, flags_d, set_vec;

  for (genvar t = 0; t < NUM_REQ; t++) begin : g_grp
    logic hit;
    assign hit                    = set_en && (set_kind == req_kind_t'(t));
    assign set_vec[t*GRP_W]       = hit && !set_err;
    assign set_vec[t*GRP_W + 1]   = hit && set_err;
    assign set_vec[t*GRP_W + 2]   = 1'b0;
    assign set_vec[t*GRP_W + 3]   = 1'b0;
  end

  // A flag being set wins over a clear on the same edge.
  always_comb begin
    flags_d = (clr ? '0 : flags_q) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

endmodule

// File: rtl/dvfs_ctrl.sv
module dvfs_ctrl
  import dvfs_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LVL_W       = 4,
  parameter int NUM_LVL0    = 8,
  parameter int NUM_LVL1    = 5,
  parameter int CFG_WORDS   = 64,
  parameter int BUSY_CYCLES = 800000,
  localparam int CFG_AW     = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  logic [7:0] reg_off;
  assign reg_off = 8'(addr);

  // Request decode
  logic      wr_l0, wr_l1, wr_cmd, req_go;
  req_kind_t req_kind;
  assign wr_l0   = wr_en && (reg_off == OFF_LVL0);
  assign wr_l1   = wr_en && (reg_off == OFF_LVL1);
  assign wr_cmd  = wr_en && (reg_off == OFF_CMD) && wdata[CMD_GO_BIT];
  assign req_go  = wr_l0 || wr_l1 || wr_cmd;

  always_comb begin
    if (wr_l1)       req_kind = REQ_CL1;
    else if (wr_cmd) req_kind = REQ_CMD;
    else             req_kind = REQ_CL0;
  end

  logic              eng_busy, eng_done, eng_err;
  req_kind_t         eng_kind;
  logic [31:0]       eng_data, cfg_data;
  logic [CFG_AW-1:0] cfg_addr;

  dvfs_op_engine #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .NUM_LVL0    (NUM_LVL0),
    .NUM_LVL1    (NUM_LVL1),
    .CFG_WORDS   (CFG_WORDS)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (req_go),
    .start_kind (req_kind),
    .start_arg  (wdata),
    .busy       (eng_busy),
    .cur_kind   (eng_kind),
    .done       (eng_done),
    .done_err   (eng_err),
    .done_data  (eng_data),
    .cfg_addr   (cfg_addr),
    .cfg_data   (cfg_data)
  );

  dvfs_cfg_mem #(
    .WORDS (CFG_WORDS)
  ) u_cfg (
    .rd_addr (cfg_addr),
    .rd_data (cfg_data)
  );

  logic              stat_rd;
  logic [STAT_W-1:0] stat_q;
  assign stat_rd = rd_en && (reg_off == OFF_STAT);

  dvfs_status_reg u_status (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .set_en   (eng_done),
    .set_kind (eng_kind),
    .set_err  (eng_err),
    .clr      (stat_rd),
    .flags    (stat_q)
  );

  assign irq = |stat_q;

  // Result registers
  logic [LVL_W-1:0] lvl0_q, lvl0_d, lvl1_q, lvl1_d;
  logic [31:0]      res_q, res_d;
  logic             ok_done;
  assign ok_done = eng_done && !eng_err;

  always_comb begin
    lvl0_d = lvl0_q;
    lvl1_d = lvl1_q;
    res_d  = res_q;
    if (ok_done) begin
      unique case (eng_kind)
        REQ_CL0: lvl0_d = LVL_W'(u_engine.arg_q);
        REQ_CL1: lvl1_d = LVL_W'(u_engine.arg_q);
        default: res_d  = eng_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      lvl0_q <= '0;
      lvl1_q <= '0;
      res_q  <= '0;
    end else begin
      lvl0_q <= lvl0_d;
      lvl1_q <= lvl1_d;
      res_q  <= res_d;
    end
  end

  // Read path
  logic [2:0]  inflight;
  logic [31:0] rd_mux, rdata_q;
  assign inflight[0] = eng_busy && (eng_kind == REQ_CL0);
  assign inflight[1] = eng_busy && (eng_kind == REQ_CL1);
  assign inflight[2] = eng_busy && (eng_kind == REQ_CMD);

  always_comb begin
    rd_mux = '0;
    unique case (reg_off)
      OFF_LVL0:   rd_mux = 32'(lvl0_q);
      OFF_BSY0:   rd_mux = 32'(inflight[0]);
      OFF_LVL1:   rd_mux = 32'(lvl1_q);
      OFF_BSY1:   rd_mux = 32'(inflight[1]);
      OFF_BSYC:   rd_mux = 32'(inflight[2]);
      OFF_STAT:   rd_mux = 32'(stat_q);
      OFF_PEEK:   rd_mux = 32'(stat_q);
      OFF_RDDATA: rd_mux = res_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/dvfs_ctrl_chk.sv
module dvfs_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic        stat_rd,
  input logic        busy,
  input logic        done,
  input logic        done_err,
  input logic [1:0]  kind,
  input logic [2:0]  inflight,
  input logic [11:0] stat,
  input logic [3:0]  lvl0
);

  p_one_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inflight));

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(kind)));

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_rd) |=> irq);

  p_rd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done) |=> !irq);

  p_irq_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done));

  p_one_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !stat_rd) |=> ($countones(stat & ~$past(stat)) <= 1));

  p_lvl_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && !done_err && kind == 2'd0) |=> $stable(lvl0));

  p_flag_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stat_rd) |=> irq);

endmodule

bind dvfs_ctrl dvfs_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .irq      (irq),
  .stat_rd  (stat_rd),
  .busy     (eng_busy),
  .done     (eng_done),
  .done_err (eng_err),
  .kind     (eng_kind),
  .inflight (inflight),
  .stat     (stat_q),
  .lvl0     (lvl0_q)
);

// File: tb/tb_dvfs_ctrl.sv
module tb_dvfs_ctrl;

  localparam int BUSY = 16;

  logic        clk, rst_n, wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  logic [31:0] got;

  dvfs_ctrl #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  typedef struct packed {
    logic [7:0]  a;
    logic [31:0] wd;
    logic [11:0] st;
    logic [7:0]  ca;
    logic [31:0] cv;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    {8'h00, 32'd3,        12'h001, 8'h00, 32'd3},        // R2 R5 cluster 0 ok
    {8'h08, 32'd4,        12'h010, 8'h08, 32'd4},        // R3 cluster 1 ok at top of range
    {8'h00, 32'd8,        12'h002, 8'h00, 32'd3},        // R4 one past cluster 0 range
    {8'h08, 32'd5,        12'h020, 8'h08, 32'd4},        // R4 one past cluster 1 range
    {8'h10, 32'h80600005, 12'h100, 8'h74, 32'hC5A50024}, // R6 R8 word 5
    {8'h10, 32'h8060003F, 12'h100, 8'h74, 32'hC59F01BA}, // R6 last word
    {8'h10, 32'h80600040, 12'h200, 8'h74, 32'hC59F01BA}, // R6 R8 offset out of range
    {8'h10, 32'h80E00000, 12'h100, 8'h74, 32'h00050008}, // R6 level counts
    {8'h10, 32'h80300000, 12'h200, 8'h74, 32'h00050008}, // R6 R8 bad function
    {8'h00, 32'd7,        12'h001, 8'h00, 32'd7},        // R5 highest valid index
    {8'h10, 32'h80600000, 12'h100, 8'h74, 32'hC5A00001}  // R6 word 0
  };

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 irq", 32'(irq), 32'd0);
    bus_read(8'h00, got); check("R1 lvl0", got, 0);
    bus_read(8'h08, got); check("R1 lvl1", got, 0);
    bus_read(8'h1C, got); check("R1 status", got, 0);
    bus_read(8'h74, got); check("R1 rddata", got, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      bus_write(VECS[i].a, VECS[i].wd);
      repeat (BUSY - 1) @(negedge clk);
      check("R2 irq before latency", 32'(irq), 32'd0);
      @(negedge clk);
      check("R2 irq at latency", 32'(irq), 32'd1);
      bus_read(8'h1C, got); check("R9 peek", got, 32'(VECS[i].st));
      bus_read(8'h18, got); check("R3 status", got, 32'(VECS[i].st));
      check("R9 irq cleared", 32'(irq), 32'd0);
      bus_read(VECS[i].ca, got); check("R5 R6 R8 result", got, VECS[i].cv);
    end

    // R7: command without start bit
    bus_write(8'h10, 32'h00600005);
    bus_read(8'h14, got); check("R7 not busy", got, 0);
    repeat (BUSY + 4) @(negedge clk);
    check("R7 irq", 32'(irq), 32'd0);
    bus_read(8'h1C, got); check("R7 status", got, 0);

    // R10: requests during busy are ignored
    bus_write(8'h00, 32'd2);
    bus_write(8'h08, 32'd1);
    bus_write(8'h10, 32'h80600005);
    bus_read(8'h04, got); check("R2 busy flag cl0", got, 1);
    bus_read(8'h0C, got); check("R10 busy flag cl1", got, 0);
    repeat (BUSY + 4) @(negedge clk);
    bus_read(8'h18, got); check("R10 status", got, 32'h001);
    bus_read(8'h00, got); check("R10 lvl0", got, 2);
    bus_read(8'h08, got); check("R10 lvl1", got, 4);
    bus_read(8'h74, got); check("R10 rddata", got, 32'hC5A00001);

    // R11: status read on the same edge as a flag being set
    bus_write(8'h08, 32'd0);
    repeat (BUSY - 2) @(negedge clk);
    bus_read(8'h18, got); check("R11 old flags", got, 0);
    check("R11 irq kept", 32'(irq), 32'd1);
    bus_read(8'h18, got); check("R11 flag kept", got, 32'h010);
    bus_read(8'h08, got); check("R5 lvl1", got, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule